// File: doc/BRIEF.md
# Serial Flash Read Responder

This block plays the memory side of a serial flash bus for read traffic only. While the chip select is low it gathers a one-byte command and a start address from the serial input. The address is three or four bytes long, depending on the command and on a static addressing-mode input. For the fast variant it then skips a block of dummy clocks, whose count a static latency input selects. After that it streams bytes from an internal byte array onto the serial output. The output enable stays low until real data is driven. The stream continues with the next address after every byte and folds back to address zero past the top of the array. Raising the chip select ends the command at once.

The bus pins are sampled by a fast system clock, which also runs a byte-wide preload port that fills the array before reads begin. Serial clock edges are found by comparing the serial clock with its value on the previous system clock cycle. Inputs are taken on a detected rising edge and output bits are launched on a detected falling edge. The serial clock must therefore run well below the system clock.

Top module: `spi_rd_responder`

## Requirements
- R1: With `ext_addr` = 0, command 8'h03 (plain read) and command 8'h0B (fast read) each take a 3-byte address, sent MSB first, before data.
- R2: With `ext_addr` = 1, commands 8'h03 and 8'h0B each take a 4-byte address instead.
- R3: Commands 8'h13 (plain read) and 8'h0C (fast read) always take a 4-byte address, regardless of `ext_addr`.
- R4: The fast commands 8'h0B and 8'h0C insert 8 dummy clocks after the address when `lat_code` is 2'b00, 2'b01 or 2'b10, and none when it is 2'b11. The plain commands 8'h03 and 8'h13 never insert dummy clocks.
- R5: `so_oe` is low throughout the command byte, the address and the dummy clocks.
- R6: `si` is taken on rising serial clock edges. Data bits change only after falling serial clock edges, MSB of each byte first. The first data bit is valid at the first rising edge after the last address or dummy clock.
- R7: After each full byte is sent, the read address moves to the next byte, so consecutive bytes come from consecutive addresses.
- R8: Only the low `AW` address bits (12 by default, a 4096-byte array) select a byte. Reading past the last byte continues at byte 0 without a gap.
- R9: When `cs_n` goes high, `so_oe` drops within two system clocks and the command is abandoned. The next low period begins with a fresh command byte.
- R10: A command byte other than 8'h03, 8'h0B, 8'h13 or 8'h0C is ignored: `so_oe` stays low for the rest of that low period on `cs_n`.
- R11: A system clock edge with `pl_we` high writes `pl_data` into the array at `pl_addr`, and a later read returns that byte.
- R12: After reset, `so_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus and runs the preload port |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock, idle low |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial command and address input |
| ext_addr | input | 1 | Addressing mode: 1 gives 4-byte addresses to 8'h03 and 8'h0B |
| lat_code | input | 2 | Latency select: 2'b11 means no dummy clocks for fast reads |
| pl_we | input | 1 | Preload write strobe |
| pl_addr | input | AW | Preload byte address |
| pl_data | input | 8 | Preload byte |
| so | output | 1 | Serial data output |
| so_oe | output | 1 | Output enable for `so` |

## Verification
The hardest situation to reach is wraparound past the top of the array in the middle of a stream. It is reached by starting reads a few bytes below the top, once with a 3-byte address and once with a 4-byte address whose upper bits are non-zero, so the dropped high bits are exercised as well. Address-length and dummy-count errors cannot be seen directly at the pins. They are exposed because a misaligned address or data phase shifts every returned byte, and each byte is compared with an independent model of the array. Aborted commands and unknown command bytes are each followed by a normal read, to show that the state was cleared.

// File: rtl/spi_rd_responder.sv
module spi_rd_responder #(
  parameter int AW    = 12,
  parameter int DUMMY = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck,
  input  logic          cs_n,
  input  logic          si,
  input  logic          ext_addr,
  input  logic [1:0]    lat_code,
  input  logic          pl_we,
  input  logic [AW-1:0] pl_addr,
  input  logic [7:0]    pl_data,
  output logic          so,
  output logic          so_oe
);
  localparam int          DEPTH = 1 << AW;
  localparam logic [4:0]  DLAST = 5'(DUMMY - 1);
  localparam logic [AW-1:0] ONE = 1;

  typedef enum logic [2:0] {S_CMD, S_ADR, S_DMY, S_DAT, S_IGN} st_t;

  st_t           st;
  logic          sck_q;
  logic [4:0]    cnt;
  logic [6:0]    op_sh;
  logic [AW-1:0] addr;
  logic [7:0]    obyte;
  logic [2:0]    ocnt;
  logic          four, fast;
  logic [7:0]    mem [DEPTH];

  wire rise = sck & ~sck_q;
  wire fall = ~sck & sck_q;

  wire [7:0] op      = {op_sh, si};
  wire       op_rd3  = (op == 8'h03) || (op == 8'h0B);
  wire       op_rd4  = (op == 8'h13) || (op == 8'h0C);
  wire       op_fast = (op == 8'h0B) || (op == 8'h0C);

  wire [AW-1:0] addr_nx  = {addr[AW-2:0], si};
  wire [AW-1:0] addr_inc = addr + ONE;
  wire [4:0]    alast    = four ? 5'd31 : 5'd23;
  wire          no_dummy = !fast || (lat_code == 2'b11);

  logic in_dat, in_ign;
  assign in_dat = (st == S_DAT);
  assign in_ign = (st == S_IGN);

  always_ff @(posedge clk)
    if (pl_we) mem[pl_addr] <= pl_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_CMD;
      cnt   <= '0;
      op_sh <= '0;
      addr  <= '0;
      obyte <= '0;
      ocnt  <= '0;
      four  <= 1'b0;
      fast  <= 1'b0;
      so    <= 1'b0;
      so_oe <= 1'b0;
    end else if (cs_n) begin
      st    <= S_CMD;
      cnt   <= '0;
      ocnt  <= '0;
      so_oe <= 1'b0;
    end else begin
      case (st)
        S_CMD: if (rise) begin
          op_sh <= op[6:0];
          cnt   <= cnt + 5'd1;
          if (cnt == 5'd7) begin
            cnt  <= '0;
            four <= op_rd4 | (op_rd3 & ext_addr);
            fast <= op_fast;
            st   <= (op_rd3 | op_rd4) ? S_ADR : S_IGN;
          end
        end
        S_ADR: if (rise) begin
          addr <= addr_nx;
          cnt  <= cnt + 5'd1;
          if (cnt == alast) begin
            cnt <= '0;
            if (no_dummy) begin
              st    <= S_DAT;
              obyte <= mem[addr_nx];
              ocnt  <= '0;
            end else begin
              st <= S_DMY;
            end
          end
        end
        S_DMY: if (rise) begin
          cnt <= cnt + 5'd1;
          if (cnt == DLAST) begin
            cnt   <= '0;
            st    <= S_DAT;
            obyte <= mem[addr];
            ocnt  <= '0;
          end
        end
        S_DAT: if (fall) begin
          so    <= obyte[7];
          so_oe <= 1'b1;
          ocnt  <= ocnt + 3'd1;
          if (ocnt == 3'd7) begin
            addr  <= addr_inc;
            obyte <= mem[addr_inc];
          end else begin
            obyte <= {obyte[6:0], 1'b0};
          end
        end
        default: ;
      endcase
    end
  end
endmodule

module spi_rd_responder_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          sck,
  input logic          so,
  input logic          so_oe,
  input logic          in_dat,
  input logic          in_ign,
  input logic [AW-1:0] addr
);
  localparam logic [AW-1:0] ONE = 1;

  p_oe_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> !so_oe);

  p_oe_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_dat |-> !so_oe);

  p_so_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(so) |-> ($past(sck) == 1'b0 && $past(sck, 2) == 1'b1));

  p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_dat && $past(in_dat) && !$stable(addr) && $past(addr) != '1)
      |-> addr == $past(addr) + ONE);

  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_dat && $past(in_dat) && !$stable(addr) && $past(addr) == '1)
      |-> addr == '0);

  p_ignore_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ign && !cs_n) |=> in_ign);

  p_reset_oe_r12: assert property (@(posedge clk)
    !rst_n |=> !so_oe);
endmodule

bind spi_rd_responder spi_rd_responder_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .so(so),
  .so_oe(so_oe), .in_dat(in_dat), .in_ign(in_ign), .addr(addr)
);

// File: tb/spi_rd_responder_test.sv
module spi_rd_responder_test;
  localparam int AW = 12;
  localparam int N  = 1 << AW;

  logic clk = 0, rst_n = 0, sck = 0, cs_n = 1, si = 0, ext_addr = 0;
  logic [1:0] lat_code = 2'b00;
  logic pl_we = 0;
  logic [AW-1:0] pl_addr = '0;
  logic [7:0] pl_data = '0;
  logic so, so_oe;

  int nchk = 0, nerr = 0;
  bit finished = 0;
  logic [7:0] model [N];
  logic [7:0] exp_q[$];
  logic [7:0] act_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  spi_rd_responder #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .ext_addr(ext_addr), .lat_code(lat_code), .pl_we(pl_we),
    .pl_addr(pl_addr), .pl_data(pl_data), .so(so), .so_oe(so_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + (a >> 5)) ^ 8'hA5);
  endfunction

  task automatic bitx(input logic b, output logic r, output logic oe);
    si = b;
    repeat (4) @(negedge clk);
    r  = so;
    oe = so_oe;
    sck = 1;
    repeat (4) @(negedge clk);
    sck = 0;
  endtask

  task automatic bytex(input logic [7:0] tx, output logic [7:0] rx,
                       output logic oe_any, output logic oe_all);
    logic r, oe;
    oe_any = 0; oe_all = 1;
    for (int i = 7; i >= 0; i--) begin
      bitx(tx[i], r, oe);
      rx[i] = r;
      oe_any |= oe;
      oe_all &= oe;
    end
  endtask

  task automatic end_cmd();
    cs_n = 1;
    repeat (3) @(negedge clk);
    chk(so_oe == 1'b0, "R9 oe after cs high", so_oe, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic read_cmd(input logic [7:0] op, input logic ext, input logic [1:0] lat,
                          input logic [31:0] a, input int nab, input int ndm,
                          input int n, input string tag);
    logic [7:0] rx;
    logic any, all, r, oe, quiet;
    ext_addr = ext; lat_code = lat;
    @(negedge clk); cs_n = 0;
    repeat (2) @(negedge clk);
    quiet = 1;
    bytex(op, rx, any, all); quiet &= !any;
    for (int i = nab - 1; i >= 0; i--) begin
      bytex(a[8*i +: 8], rx, any, all);
      quiet &= !any;
    end
    for (int i = 0; i < ndm; i++) begin
      bitx(1'b0, r, oe);
      quiet &= !oe;
    end
    chk(quiet, {"R5 oe low before data, ", tag}, !quiet, 0);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(model[int'((a + 32'(i)) & 32'(N - 1))]);
      tag_q.push_back(tag);
      bytex(8'h00, rx, any, all);
      act_q.push_back(rx);
      chk(all, {"R6 oe during data, ", tag}, all, 1);
    end
    end_cmd();
  endtask

  initial begin : monitor
    logic [7:0] r, e;
    string t;
    forever begin
      wait (act_q.size() > 0);
      r = act_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(r === e, t, r, e);
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin : driver
    logic [7:0] rx;
    logic any, all, quiet;
    repeat (3) @(negedge clk);
    chk(so_oe == 1'b0, "R12 oe in reset", so_oe, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(so_oe == 1'b0, "R12 oe after reset", so_oe, 0);

    for (int i = 0; i < N; i++) begin
      model[i] = pat(i);
      pl_we = 1; pl_addr = AW'(i); pl_data = pat(i);
      @(negedge clk);
    end
    pl_we = 0;

    read_cmd(8'h03, 0, 2'b00, 32'h000123, 3, 0, 5, "R1 R6 plain 3-byte");
    read_cmd(8'h0B, 0, 2'b00, 32'h000456, 3, 8, 4, "R1 R4 fast 3-byte lat0");
    read_cmd(8'h0B, 0, 2'b11, 32'h000789, 3, 0, 3, "R4 fast lat3 no dummy");
    read_cmd(8'h03, 1, 2'b10, 32'h00000ABC, 4, 0, 3, "R2 plain ext 4-byte");
    read_cmd(8'h0B, 1, 2'b10, 32'h00000531, 4, 8, 3, "R2 R4 fast ext lat2");
    read_cmd(8'h13, 0, 2'b11, 32'h00000246, 4, 0, 3, "R3 4-byte plain ext0");
    read_cmd(8'h0C, 0, 2'b01, 32'h00000357, 4, 8, 3, "R3 R4 4-byte fast lat1");
    read_cmd(8'h0C, 1, 2'b11, 32'h00000468, 4, 0, 2, "R3 R4 4-byte fast lat3");
    read_cmd(8'h03, 0, 2'b00, 32'h000FFD, 3, 0, 6, "R8 wrap 3-byte");
    read_cmd(8'h13, 0, 2'b00, 32'h12345FFE, 4, 0, 5, "R8 wrap high bits");
    read_cmd(8'h03, 0, 2'b00, 32'h000800, 3, 0, 20, "R7 long stream");

    @(negedge clk); cs_n = 0;
    repeat (2) @(negedge clk);
    quiet = 1;
    bytex(8'h9F, rx, any, all); quiet &= !any;
    for (int i = 0; i < 5; i++) begin
      bytex(8'h00, rx, any, all);
      quiet &= !any;
    end
    chk(quiet, "R10 unknown command oe", !quiet, 0);
    end_cmd();
    read_cmd(8'h03, 0, 2'b00, 32'h000010, 3, 0, 2, "R10 read after unknown");

    @(negedge clk); cs_n = 0;
    repeat (2) @(negedge clk);
    bytex(8'h03, rx, any, all);
    bytex(8'h07, rx, any, all);
    end_cmd();
    read_cmd(8'h0B, 0, 2'b00, 32'h000ABC, 3, 8, 3, "R9 read after abort");

    pl_we = 1; pl_addr = 12'h321; pl_data = 8'h3C;
    @(negedge clk);
    pl_we = 0;
    model[12'h321] = 8'h3C;
    read_cmd(8'h03, 0, 2'b00, 32'h000320, 3, 0, 3, "R11 preload overwrite");

    wait (act_q.size() == 0);
    repeat (2) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule